// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block divides a slow timebase, given as a one-cycle tick enable, into periodic events. A 4-bit rate code selects the period. When a period completes, the block pulses a periodic-flag set output. It also pulses an interrupt request, but only if periodic interrupts are enabled. The surrounding register logic uses the flag pulse to set its status bit and the request pulse to set its interrupt bits.

The rate code and the interrupt enable are taken in on a configuration strobe. A change of rate does not restart the period. The ticks already counted since the last event are kept, and the next event is measured against the new period. If more ticks have already passed than the new period allows, the event comes on the next tick and the missed events are dropped.

Top module: `rtc_periodic_gen`

## Requirements
- R1: After reset the latched rate code is 0. While the latched code is 0, neither `pf_set` nor `irq_req` pulses, and the tick count is held at zero, so the first period after enabling is a full one.
- R2: The period in ticks is set by the latched 4-bit code. Code 1 gives 128 ticks and code 2 gives 256 ticks. Codes 3 to 15 give 2^(code-1) ticks (code 3 is 4 ticks, code 15 is 16384 ticks). The event pulses on the tick that completes the period.
- R3: `pf_set` pulses at every period boundary, whatever the value of the interrupt enable.
- R4: `irq_req` pulses only in a cycle where `pf_set` pulses and the latched interrupt enable is 1. It never pulses while the latched enable is 0.
- R5: `rate_sel` and `pie_en` are latched only in a cycle with `cfg_change` high, and take effect from the next cycle. Changes made without the strobe have no effect.
- R6: On a change from one nonzero code to another, the ticks counted since the last event are kept. The next event comes after (new period - ticks already counted) further ticks.
- R7: If the ticks already counted reach or exceed the new period minus one, the event pulses on the very next tick. After that, full new periods follow.
- R8: `pf_set` and `irq_req` are combinational pulses, high only in a cycle where `tick_en` is high. Each is one cycle wide while ticks are one cycle apart.
- R9: A tick in the same cycle as `cfg_change` is counted under the configuration in force before the strobe. This holds even when that tick completes the old period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle timebase tick |
| rate_sel | input | CODE_W | Rate code, taken in on `cfg_change` |
| pie_en | input | 1 | Periodic interrupt enable, taken in on `cfg_change` |
| cfg_change | input | 1 | Configuration strobe |
| pf_set | output | 1 | Periodic flag set pulse |
| irq_req | output | 1 | Interrupt request pulse |

## Verification
A configuration strobe can land in the same cycle as the tick that completes a period. In that case the tick must be judged under the old rate, and a strobe that disables the generator must still let that final event out. The bench syncs to an event, waits exactly one tick short of the period, and then strobes code 0. It expects `pf_set` in the strobe cycle itself, and silence afterwards. A behavioural model that counts ticks as integers is compared with both outputs on every clock, so retimed rate changes and overshoot cases are checked cycle by cycle as well.

// File: rtl/rtc_prd_pkg.sv
`timescale 1ns/1ps
package rtc_prd_pkg;

   // Exponent of the period (in ticks) selected by a rate code; 0 for the off code.
   function automatic int shift_for_code(input int code, input int alias_codes,
                                         input int alias_shift);
      if (code == 0)
         return 0;
      if (code <= alias_codes)
         return alias_shift + code - 1;
      return code - 1;
   endfunction

endpackage

// File: rtl/rtc_prd_cfg_latch.sv
`timescale 1ns/1ps
module rtc_prd_cfg_latch #(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_change,
   input  logic [CODE_W-1:0] rate_sel,
   input  logic              pie_en,
   output logic [CODE_W-1:0] code_q,
   output logic              pie_q,
   output logic              phase_clr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         pie_q  <= 1'b0;
      end else if (cfg_change) begin
         code_q <= rate_sel;
         pie_q  <= pie_en;
      end
   end

   // A strobe that turns the generator off discards the partial period.
   assign phase_clr = cfg_change && (rate_sel == '0);

endmodule

// File: rtl/rtc_prd_rate_decode.sv
`timescale 1ns/1ps
module rtc_prd_rate_decode #(
   parameter int CODE_W      = 4,
   parameter int CNT_W       = 14,
   parameter int ALIAS_CODES = 2,
   parameter int ALIAS_SHIFT = 7
) (
   input  logic [CODE_W-1:0] code,
   output logic              active,
   output logic [CNT_W-1:0]  last_cnt
);

   localparam int NCODES = 1 << CODE_W;

   logic [CNT_W-1:0] last_tab [NCODES];

   for (genvar g = 0; g < NCODES; g++) begin : g_tab
      localparam int SH = rtc_prd_pkg::shift_for_code(g, ALIAS_CODES, ALIAS_SHIFT);
      if (g == 0) begin : g_off
         assign last_tab[g] = '0;
      end else begin : g_on
         assign last_tab[g] = CNT_W'((64'd1 << SH) - 64'd1);
      end
   end

   assign active   = (code != '0);
   assign last_cnt = last_tab[code];

endmodule

// File: rtl/rtc_prd_phase_counter.sv
`timescale 1ns/1ps
module rtc_prd_phase_counter #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             active,
   input  logic             phase_clr,
   input  logic [CNT_W-1:0] last_cnt,
   output logic             fire
);

   logic [CNT_W-1:0] elapsed_q;

   // An overshoot after a rate change (elapsed past last_cnt) fires at once.
   assign fire = tick_en && active && (elapsed_q >= last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed_q <= '0;
      end else if (phase_clr || !active) begin
         elapsed_q <= '0;
      end else if (tick_en) begin
         elapsed_q <= fire ? '0 : elapsed_q + 1'b1;
      end
   end

endmodule

// File: rtl/rtc_periodic_gen.sv
`timescale 1ns/1ps
module rtc_periodic_gen #(
   parameter int CODE_W      = 4,
   parameter int ALIAS_CODES = 2,
   parameter int ALIAS_SHIFT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [CODE_W-1:0] rate_sel,
   input  logic              pie_en,
   input  logic              cfg_change,
   output logic              pf_set,
   output logic              irq_req
);

   localparam int CNT_W = (1 << CODE_W) - 2;

   initial begin
      assert (CODE_W >= 2 && CODE_W <= 5)
         else $error("CODE_W out of range");
      assert (ALIAS_CODES < (1 << CODE_W))
         else $error("ALIAS_CODES too large");
      assert (ALIAS_SHIFT + ALIAS_CODES - 1 <= CNT_W)
         else $error("alias periods exceed counter width");
   end

   logic [CODE_W-1:0] code_q;
   logic              pie_q;
   logic              phase_clr;
   logic              active;
   logic [CNT_W-1:0]  last_cnt;
   logic              fire;

   rtc_prd_cfg_latch #(.CODE_W(CODE_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_change(cfg_change),
      .rate_sel(rate_sel), .pie_en(pie_en),
      .code_q(code_q), .pie_q(pie_q), .phase_clr(phase_clr)
   );

   rtc_prd_rate_decode #(
      .CODE_W(CODE_W), .CNT_W(CNT_W),
      .ALIAS_CODES(ALIAS_CODES), .ALIAS_SHIFT(ALIAS_SHIFT)
   ) u_dec (
      .code(code_q), .active(active), .last_cnt(last_cnt)
   );

   rtc_prd_phase_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .active(active),
      .phase_clr(phase_clr), .last_cnt(last_cnt), .fire(fire)
   );

   assign pf_set  = fire;
   assign irq_req = fire && pie_q;

endmodule

// File: rtl/rtc_periodic_gen_chk.sv
`timescale 1ns/1ps
module rtc_periodic_gen_chk #(
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic [CODE_W-1:0] rate_sel,
   input logic              pie_en,
   input logic              cfg_change,
   input logic              pf_set,
   input logic              irq_req
);

   logic [CODE_W-1:0] sh_code;
   logic              sh_pie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_code <= '0;
         sh_pie  <= 1'b0;
      end else if (cfg_change) begin
         sh_code <= rate_sel;
         sh_pie  <= pie_en;
      end
   end

   AST_IRQ_WITH_PF: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> pf_set); // R4
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_pie |-> !irq_req); // R4
   AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_set || irq_req) |-> tick_en); // R8
   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_code == '0) |-> !pf_set); // R1

endmodule

bind rtc_periodic_gen rtc_periodic_gen_chk #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
   .pie_en(pie_en), .cfg_change(cfg_change), .pf_set(pf_set), .irq_req(irq_req)
);

// File: tb/rtc_periodic_gen_tb.sv
`timescale 1ns/1ps
module rtc_periodic_gen_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [3:0] rate_sel = '0;
   logic       pie_en = 1'b0;
   logic       cfg_change = 1'b0;
   logic       pf_set, irq_req;

   int checks = 0;
   int errors = 0;
   int tick_div = 1;
   int tcnt = 0;
   int cyc = 0;

   rtc_periodic_gen u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
      .pie_en(pie_en), .cfg_change(cfg_change), .pf_set(pf_set), .irq_req(irq_req)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      #1;
      tcnt = (tcnt + 1) % tick_div;
      tick_en = (tcnt == 0);
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         check(1'b0, "watchdog", cyc, 150000);
         finish_run();
      end
   end

   // Behavioural reference: ticks since last event as an integer.
   int m_code = 0, m_pie = 0, m_el = 0;

   function automatic int period_of(input int code);
      if (code == 0) return 0;
      if (code <= 2) return 1 << (6 + code);
      return 1 << (code - 1);
   endfunction

   always @(negedge clk) begin
      bit ep, ei;
      if (!rst_n) begin
         m_code = 0; m_pie = 0; m_el = 0;
      end else begin
         ep = tick_en && (m_code != 0) && (m_el + 1 >= period_of(m_code));
         ei = ep && (m_pie != 0);
         check(pf_set == ep, "R3 model pf_set", pf_set, ep);
         check(irq_req == ei, "R4 model irq_req", irq_req, ei);
         if ((cfg_change && rate_sel == 0) || m_code == 0) m_el = 0;
         else if (tick_en) m_el = ep ? 0 : m_el + 1;
         if (cfg_change) begin m_code = rate_sel; m_pie = pie_en; end
      end
   end

   task automatic set_cfg(input int code, input bit pie);
      @(posedge clk); #1;
      cfg_change = 1'b1; rate_sel = 4'(code); pie_en = pie;
      @(posedge clk); #1;
      cfg_change = 1'b0;
   endtask

   task automatic measure(output int n, output bit irq_seen);
      int c;
      n = 0; c = 0; irq_seen = 0;
      forever begin
         @(negedge clk);
         c++;
         if (tick_en) n++;
         if (pf_set) begin irq_seen = irq_req; break; end
         if (c > 40000) begin n = -1; break; end
      end
   endtask

   initial begin
      int n, pulses;
      bit irq;
      int codes[5] = '{1, 2, 3, 7, 15};

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state, generator off
      pulses = 0;
      repeat (200) begin @(negedge clk); if (pf_set || irq_req) pulses++; end
      check(pulses == 0, "R1 pulses after reset", pulses, 0);

      // R2, R3: periods per code with interrupts masked; R1 full period after off
      foreach (codes[i]) begin
         set_cfg(0, 0);
         set_cfg(codes[i], 0);
         measure(n, irq);
         check(n == period_of(codes[i]), $sformatf("R2 period code %0d", codes[i]),
               n, period_of(codes[i]));
         check(irq == 0, "R4 irq masked", irq, 0);
      end

      // R4: enabled interrupt accompanies flag
      set_cfg(0, 0);
      set_cfg(3, 1);
      measure(n, irq);
      check(n == 4, "R2 code 3", n, 4);
      check(irq == 1, "R4 irq with pf", irq, 1);
      // R8: one cycle wide
      @(negedge clk);
      check(pf_set == 0, "R8 pulse width", pf_set, 0);

      // R5: inputs without strobe ignored
      @(posedge clk); #1 rate_sel = 4'd15; pie_en = 1'b0;
      measure(n, irq);
      measure(n, irq);
      check(n == 4, "R5 period unchanged", n, 4);
      check(irq == 1, "R5 pie unchanged", irq, 1);

      // R6: rate change keeps elapsed ticks (64 period, 10 waited + strobe tick)
      set_cfg(6, 1);
      measure(n, irq);
      repeat (10) @(negedge clk);
      set_cfg(7, 1);
      measure(n, irq);
      check(n == 64 - 11, "R6 retimed event", n, 53);
      measure(n, irq);
      check(n == 64, "R6 full period after", n, 64);

      // R7: overshoot fires next tick
      repeat (40) @(negedge clk);
      set_cfg(3, 0);
      measure(n, irq);
      check(n == 1, "R7 overshoot", n, 1);
      measure(n, irq);
      check(n == 4, "R7 then full period", n, 4);

      // R9: strobe to code 0 on the completing tick
      repeat (3) @(negedge clk);
      @(posedge clk); #1;
      cfg_change = 1'b1; rate_sel = 4'd0; pie_en = 1'b0;
      @(negedge clk);
      check(pf_set == 1, "R9 old config tick fires", pf_set, 1);
      @(posedge clk); #1 cfg_change = 1'b0;
      pulses = 0;
      repeat (50) begin @(negedge clk); if (pf_set) pulses++; end
      check(pulses == 0, "R1 silent after off", pulses, 0);

      // R8: sparse ticks, pulses only with tick_en
      tick_div = 3;
      set_cfg(3, 1);
      pulses = 0;
      repeat (60) begin
         @(negedge clk);
         if (pf_set) begin
            pulses++;
            check(tick_en == 1, "R8 pulse on tick", tick_en, 1);
         end
      end
      check(pulses >= 4, "R8 pulses with sparse ticks", pulses, 4);

      finish_run();
   end

endmodule